// File: doc/BRIEF.md
# External Bus Release Handshake Controller

This block decides who owns the external bus pins of a microcontroller bus controller. An outside master asks for the bus with an active-low request input. The block answers on an active-low acknowledge pin. It also drives the output enables for the address, data and bus-control pins, and a separate enable for the DRAM control pins. In the normal state, a request is granted at a bus-cycle boundary. The acknowledge then goes low and the bus pins float. When the request is withdrawn, the block takes the bus back.

Software standby changes the rules. While standby is active, the request input is ignored and the bus pins float, but the DRAM pins stay driven. What the acknowledge pin does in standby depends on the state held when standby began. If the bus was released, the acknowledge is driven high. If the bus was not released, the acknowledge pin itself floats. On exit from standby from the non-released case with a request pending, the acknowledge is first driven high for one and a half external clock periods. The bus is then granted. That interval is timed in half periods on an internal clock that runs at twice the external rate.

A locked read-modify-write instruction blocks a grant, unless DMA cycles have been inserted between its read and its write. The request input is synchronised by a two-flop chain before it is used.

Top module: `bus_release_ctrl`

## Requirements
- R1: A synchronous reset with `rst_n` low puts the block in the normal state: `back_oe`=1, `back_val`=1, `bus_oe`=1, `dram_oe`=1.
- R2: `breq_n` passes through two synchronising flops. With `cycle_end` held high, a change on `breq_n` made before rising edge k shows at the outputs after rising edge k+2.
- R3: A grant (normal to released) and a return (released to normal) happen only on rising edges where `cycle_end` is 1.
- R4: While `rmw_lock`=1 and `rmw_dma`=0, a pending request is not granted. With `rmw_lock`=1 and `rmw_dma`=1, it is granted.
- R5: In the released state, `back_oe`=1, `back_val`=0, `bus_oe`=0 and `dram_oe`=0.
- R6: When `stby` is raised in the normal state, the next edge gives `back_oe`=0 (acknowledge floats), `bus_oe`=0 and `dram_oe`=1.
- R7: When `stby` is raised in the released state, the next edge gives `back_oe`=1, `back_val`=1, `bus_oe`=0 and `dram_oe`=1.
- R8: While `stby`=1, changes on `breq_n` do not alter any output.
- R9: When `stby` falls after standby was entered from the released state, the next edge gives the released state if the synchronised request is active. Otherwise it gives the normal state.
- R10: When `stby` falls after standby was entered from the normal state with no request active, the next edge gives the normal state.
- R11: When `stby` falls after standby was entered from the normal state with a request active, `back_oe`=1, `back_val`=1, `bus_oe`=0 and `dram_oe`=1 hold for exactly `HALF_CYCLES` clock cycles (default 3, which is 1.5 external clocks). The released state then follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock at twice the external bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| breq_n | input | 1 | Bus request from the outside master, active low, asynchronous |
| stby | input | 1 | Software standby active, synchronous to `clk` |
| cycle_end | input | 1 | Marks a bus-cycle boundary edge |
| rmw_lock | input | 1 | A locked read-modify-write instruction is executing |
| rmw_dma | input | 1 | DMA cycles are inserted inside the locked instruction |
| back_val | output | 1 | Level driven on the acknowledge pin (active low) |
| back_oe | output | 1 | Output enable of the acknowledge pin |
| bus_oe | output | 1 | Output enable of the address, data and bus-control pins |
| dram_oe | output | 1 | Output enable of the DRAM control pins |

## Verification
The bench goes after the two standby exits that a request can hit. If the exit from non-released standby skipped the high interval, the acknowledge would fall on the first edge. If the interval were off by one, the acknowledge would fall one half period early or late. Both errors show as a wrong acknowledge level on an exact cycle. The bench also toggles the request during standby: a design that listened to it would leave standby or flip the acknowledge. It holds a request under a locked instruction with and without inserted DMA: a design that ignored the lock would grant early. It holds `cycle_end` low around request changes: a design that ignored boundaries would grant or return mid-cycle.

// File: rtl/brel_pkg.sv
// Package: shared state and pin-control types for the bus release controller.
// Assumes: one-hot-free binary encoding is adequate for five states.
package brel_pkg;

    typedef enum logic [2:0] {
        ST_NORM     = 3'd0,
        ST_REL      = 3'd1,
        ST_SBY_REL  = 3'd2,
        ST_SBY_NORM = 3'd3,
        ST_EXIT_HI  = 3'd4
    } brel_state_t;

    typedef struct packed {
        logic back_oe;
        logic back_val;
        logic bus_oe;
        logic dram_oe;
    } pin_ctl_t;

endpackage

// File: rtl/brel_sync.sv
// Module: brel_sync
// Multi-flop synchroniser for a single asynchronous level.
// Assumes: input is a slow level; RST_VAL is the inactive level.
module brel_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d_in};
    end

    assign q_out = chain[STAGES-1];
endmodule

// File: rtl/brel_halfcnt.sv
// Module: brel_halfcnt
// Down counter timing the forced-high acknowledge interval in half
// external-clock steps (one step per internal clock).
// Assumes: HALF_CYCLES >= 1; load and run are never high together.
module brel_halfcnt #(
    parameter int HALF_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic done
);
    localparam int CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
    localparam logic [CW-1:0] LOAD_VAL = CW'(HALF_CYCLES - 1);

    logic [CW-1:0] cnt;

    // Load at the start of the interval, then count down while running.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt <= '0;
        else if (load)                cnt <= LOAD_VAL;
        else if (run && cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign done = run && (cnt == '0);
endmodule

// File: rtl/brel_fsm.sv
// Module: brel_fsm
// Release state machine: normal/released handshake, standby entry
// from either state, and the three standby exit paths.
// Assumes: req is already synchronised; stby is synchronous to clk.
module brel_fsm
    import brel_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req,
    input  logic     stby,
    input  logic     cycle_end,
    input  logic     rmw_lock,
    input  logic     rmw_dma,
    input  logic     pulse_done,
    output logic     pulse_load,
    output logic     pulse_run,
    output pin_ctl_t ctl
);
    brel_state_t state, state_nx;
    logic        grant_ok;

    assign grant_ok = !rmw_lock || rmw_dma;

    // Next-state selection; standby entry takes priority over the handshake.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_NORM: begin
                if (stby)                                state_nx = ST_SBY_NORM;
                else if (req && cycle_end && grant_ok)   state_nx = ST_REL;
            end
            ST_REL: begin
                if (stby)                                state_nx = ST_SBY_REL;
                else if (!req && cycle_end)              state_nx = ST_NORM;
            end
            ST_SBY_REL: begin
                if (!stby)                               state_nx = req ? ST_REL : ST_NORM;
            end
            ST_SBY_NORM: begin
                if (!stby)                               state_nx = req ? ST_EXIT_HI : ST_NORM;
            end
            ST_EXIT_HI: begin
                if (stby)                                state_nx = ST_SBY_NORM;
                else if (pulse_done)                     state_nx = ST_REL;
            end
            default:                                     state_nx = ST_NORM;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_NORM;
        else        state <= state_nx;
    end

    assign pulse_load = (state == ST_SBY_NORM) && (state_nx == ST_EXIT_HI);
    assign pulse_run  = (state == ST_EXIT_HI);

    // Pin controls decoded from the held state.
    always_comb begin
        unique case (state)
            ST_REL:      ctl = '{back_oe: 1'b1, back_val: 1'b0, bus_oe: 1'b0, dram_oe: 1'b0};
            ST_SBY_REL:  ctl = '{back_oe: 1'b1, back_val: 1'b1, bus_oe: 1'b0, dram_oe: 1'b1};
            ST_SBY_NORM: ctl = '{back_oe: 1'b0, back_val: 1'b1, bus_oe: 1'b0, dram_oe: 1'b1};
            ST_EXIT_HI:  ctl = '{back_oe: 1'b1, back_val: 1'b1, bus_oe: 1'b0, dram_oe: 1'b1};
            default:     ctl = '{back_oe: 1'b1, back_val: 1'b1, bus_oe: 1'b1, dram_oe: 1'b1};
        endcase
    end
endmodule

// File: rtl/bus_release_ctrl.sv
// Module: bus_release_ctrl (top)
// External bus release handshake with software-standby sequencing.
// Assumes: clk runs at twice the external bus clock; cycle_end marks
// bus-cycle boundaries; the acknowledge pad is built from back_val/back_oe.
module bus_release_ctrl
    import brel_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HALF_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic breq_n,
    input  logic stby,
    input  logic cycle_end,
    input  logic rmw_lock,
    input  logic rmw_dma,
    output logic back_val,
    output logic back_oe,
    output logic bus_oe,
    output logic dram_oe
);
    logic     breq_n_s;
    logic     req;
    logic     pulse_load;
    logic     pulse_run;
    logic     pulse_done;
    pin_ctl_t ctl;

    brel_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (breq_n),
        .q_out (breq_n_s)
    );

    assign req = !breq_n_s;

    brel_halfcnt #(.HALF_CYCLES(HALF_CYCLES)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (pulse_load),
        .run   (pulse_run),
        .done  (pulse_done)
    );

    brel_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .stby       (stby),
        .cycle_end  (cycle_end),
        .rmw_lock   (rmw_lock),
        .rmw_dma    (rmw_dma),
        .pulse_done (pulse_done),
        .pulse_load (pulse_load),
        .pulse_run  (pulse_run),
        .ctl        (ctl)
    );

    assign back_oe  = ctl.back_oe;
    assign back_val = ctl.back_val;
    assign bus_oe   = ctl.bus_oe;
    assign dram_oe  = ctl.dram_oe;
endmodule

// File: rtl/bus_release_ctrl_chk.sv
// Module: bus_release_ctrl_chk
// Port-level protocol checks for bus_release_ctrl, attached by bind.
// Assumes: checks are sampled on the rising edge of clk.
module bus_release_ctrl_chk #(
    parameter int HALF_CYCLES = 3
) (
    input logic clk,
    input logic rst_n,
    input logic stby,
    input logic cycle_end,
    input logic rmw_lock,
    input logic rmw_dma,
    input logic back_val,
    input logic back_oe,
    input logic bus_oe,
    input logic dram_oe
);
    logic        prev_z;
    logic        in_pulse;
    logic [15:0] run_len;
    logic        hi_float;

    assign hi_float = back_oe && back_val && !bus_oe;

    // Measure the length of a driven-high run that follows a floating acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_z   <= 1'b0;
            in_pulse <= 1'b0;
            run_len  <= '0;
        end else begin
            prev_z <= !back_oe;
            if (prev_z && hi_float) begin
                in_pulse <= 1'b1;
                run_len  <= 16'd1;
            end else if (in_pulse && hi_float) begin
                run_len  <= run_len + 16'd1;
            end else begin
                in_pulse <= 1'b0;
            end
        end
    end

    AST_RESET_NORMAL: assert property (@(posedge clk)
        !rst_n |=> (back_oe && back_val && bus_oe && dram_oe)); // R1

    AST_RELEASED_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        (back_oe && !back_val) |-> (!bus_oe && !dram_oe)); // R5

    AST_FLOAT_ACK_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        !back_oe |-> (!bus_oe && dram_oe)); // R6

    AST_GRANT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bus_oe) && !bus_oe && back_oe && !back_val)
        |-> ($past(cycle_end) && (!$past(rmw_lock) || $past(rmw_dma)))); // R3 R4

    AST_STBY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(stby) && stby)
        |=> $stable({back_oe, back_val, bus_oe, dram_oe})); // R8

    AST_EXIT_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!back_oe) && back_oe) |-> back_val); // R10

    AST_EXIT_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_pulse && back_oe && !back_val) |-> (run_len == 16'(HALF_CYCLES))); // R11

endmodule

bind bus_release_ctrl bus_release_ctrl_chk #(.HALF_CYCLES(HALF_CYCLES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stby      (stby),
    .cycle_end (cycle_end),
    .rmw_lock  (rmw_lock),
    .rmw_dma   (rmw_dma),
    .back_val  (back_val),
    .back_oe   (back_oe),
    .bus_oe    (bus_oe),
    .dram_oe   (dram_oe)
);

// File: tb/bus_release_ctrl_test.sv
// Bench: scoreboard bench for bus_release_ctrl. The driver pushes the
// expected pin pattern after each rising edge; the monitor pops and compares.
module bus_release_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    // Expected patterns {back_oe, back_val, bus_oe, dram_oe}
    localparam logic [3:0] P_NORM = 4'b1111;
    localparam logic [3:0] P_REL  = 4'b1000;
    localparam logic [3:0] P_SHI  = 4'b1101;   // acknowledge driven high, bus floating
    localparam logic [3:0] P_SZ   = 4'b0101;   // acknowledge floating (value ignored)

    typedef struct {
        logic [3:0] exp;
        string      tag;
    } exp_item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic breq_n = 1'b1;
    logic stby = 1'b0;
    logic cycle_end = 1'b1;
    logic rmw_lock = 1'b0;
    logic rmw_dma = 1'b0;
    logic back_val, back_oe, bus_oe, dram_oe;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit driver_done = 1'b0;
    exp_item_t sb_q[$];

    bus_release_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .breq_n    (breq_n),
        .stby      (stby),
        .cycle_end (cycle_end),
        .rmw_lock  (rmw_lock),
        .rmw_dma   (rmw_dma),
        .back_val  (back_val),
        .back_oe   (back_oe),
        .bus_oe    (bus_oe),
        .dram_oe   (dram_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Driver: set inputs on the falling edge, queue the pattern expected after the next rise.
    task automatic step(input logic r, input logic bq, input logic sb, input logic ce,
                        input logic lk, input logic dm, input logic [3:0] exp, input string tag);
        exp_item_t it;
        @(negedge clk);
        rst_n = r; breq_n = bq; stby = sb; cycle_end = ce; rmw_lock = lk; rmw_dma = dm;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: compare outputs shortly after each rising edge.
    always @(posedge clk) begin
        #2;
        if (sb_q.size() > 0) begin
            exp_item_t it;
            logic [3:0] act;
            logic [3:0] mask;
            it   = sb_q.pop_front();
            act  = {back_oe, back_val, bus_oe, dram_oe};
            mask = it.exp[3] ? 4'b1111 : 4'b1011;
            checks++;
            if ((act & mask) !== (it.exp & mask)) begin
                errors++;
                $display("FAIL %s: pins {oe,val,bus,dram} actual %b expected %b",
                         it.tag, act, it.exp);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected under %0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        step(0, 1, 0, 1, 0, 0, P_NORM, "R1");
        step(0, 1, 0, 1, 0, 0, P_NORM, "R1");

        // R2 request synchronised, grant on third edge; R5 released pins
        step(1, 0, 0, 1, 0, 0, P_NORM, "R2");
        step(1, 0, 0, 1, 0, 0, P_NORM, "R2");
        step(1, 0, 0, 1, 0, 0, P_REL,  "R2 R5");
        step(1, 1, 0, 1, 0, 0, P_REL,  "R2");
        step(1, 1, 0, 1, 0, 0, P_REL,  "R2");
        step(1, 1, 0, 1, 0, 0, P_NORM, "R2");

        // R3 grant and return wait for a boundary
        for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, 0, P_NORM, "R3");
        step(1, 0, 0, 1, 0, 0, P_REL, "R3");
        for (int i = 0; i < 4; i++) step(1, 1, 0, 0, 0, 0, P_REL, "R3");
        step(1, 1, 0, 1, 0, 0, P_NORM, "R3");

        // R4 locked instruction blocks grant, inserted DMA allows it
        for (int i = 0; i < 4; i++) step(1, 0, 0, 1, 1, 0, P_NORM, "R4");
        step(1, 0, 0, 1, 1, 1, P_REL, "R4");
        step(1, 1, 0, 1, 0, 0, P_REL, "R4");
        step(1, 1, 0, 1, 0, 0, P_REL, "R4");
        step(1, 1, 0, 1, 0, 0, P_NORM, "R4");

        // R7 standby from released, R8 request ignored, R9 exit with request
        step(1, 0, 0, 1, 0, 0, P_NORM, "R7");
        step(1, 0, 0, 1, 0, 0, P_NORM, "R7");
        step(1, 0, 0, 1, 0, 0, P_REL,  "R7");
        step(1, 0, 1, 1, 0, 0, P_SHI,  "R7");
        for (int i = 0; i < 4; i++) step(1, 1, 1, 1, 0, 0, P_SHI, "R8");
        for (int i = 0; i < 3; i++) step(1, 0, 1, 1, 0, 0, P_SHI, "R8");
        step(1, 0, 0, 1, 0, 0, P_REL,  "R9");
        step(1, 1, 0, 1, 0, 0, P_REL,  "R9");
        step(1, 1, 0, 1, 0, 0, P_REL,  "R9");
        step(1, 1, 0, 1, 0, 0, P_NORM, "R9");

        // R9 exit from released standby with request withdrawn
        step(1, 0, 0, 1, 0, 0, P_NORM, "R9");
        step(1, 0, 0, 1, 0, 0, P_NORM, "R9");
        step(1, 0, 0, 1, 0, 0, P_REL,  "R9");
        step(1, 0, 1, 1, 0, 0, P_SHI,  "R7");
        for (int i = 0; i < 3; i++) step(1, 1, 1, 1, 0, 0, P_SHI, "R8");
        step(1, 1, 0, 1, 0, 0, P_NORM, "R9");

        // R6 standby from normal, R8 request ignored, R10 exit without request
        step(1, 1, 1, 1, 0, 0, P_SZ, "R6");
        for (int i = 0; i < 3; i++) step(1, 0, 1, 1, 0, 0, P_SZ, "R8");
        for (int i = 0; i < 3; i++) step(1, 1, 1, 1, 0, 0, P_SZ, "R8");
        step(1, 1, 0, 1, 0, 0, P_NORM, "R10");

        // R11 exit from normal standby with request: three half cycles high, then released
        step(1, 1, 1, 1, 0, 0, P_SZ, "R6");
        for (int i = 0; i < 3; i++) step(1, 0, 1, 1, 0, 0, P_SZ, "R8");
        step(1, 0, 0, 1, 0, 0, P_SHI, "R11");
        step(1, 0, 0, 1, 0, 0, P_SHI, "R11");
        step(1, 0, 0, 1, 0, 0, P_SHI, "R11");
        step(1, 0, 0, 1, 0, 0, P_REL, "R11");
        step(1, 1, 0, 1, 0, 0, P_REL, "R11");
        step(1, 1, 0, 1, 0, 0, P_REL, "R11");
        step(1, 1, 0, 1, 0, 0, P_NORM, "R11");

        driver_done = 1'b1;
    end

    // Finish once the driver is done and the scoreboard has drained.
    initial begin
        wait (driver_done);
        while (sb_q.size() > 0) @(posedge clk);
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule